// File: doc/BRIEF.md
# Adaptive Jitter-Buffer Slip Controller

This block tracks the fill level of a circular ring of buffer descriptors. One side of the ring is a cell-side writer that completes descriptors as cells arrive. The other side is a TDM-side reader that drains one descriptor per completed transmission at a steady frame rate. The two sides may run on clocks that are not locked to each other, so the ring can drift towards empty or towards full. The controller keeps a single occupancy count and takes action at four programmable levels.

When a reader completion brings the level down to the low stop level, the reader index freezes and the block asks the output path to send filler. The filler is either a fixed template or a repeat of the last frame, chosen by a configuration bit. The freeze is released only at a frame boundary, once the level has climbed back to the low restart level. When a writer completion brings the level up to the high stop level, the block enters hunt mode and drops incoming cells. Hunt mode ends when the level has drained to the high restart level. At that point the write index realigns to the descriptor just after the next one flagged as a superframe end.

Event counters record underrun entries, hunt entries and dropped cells. A flag reports threshold settings that are out of order. Data movement and cell parsing are handled elsewhere.

Top module: `jb_slip_ctrl`

## Requirements
- R1: The occupancy rises by one on an accepted writer completion and falls by one on an accepted reader completion. It is unchanged when both are accepted in the same cycle. It never exceeds DEPTH. A writer completion while the occupancy equals DEPTH is dropped, leaves the write index unchanged and adds one to the discard counter.
- R2: Each accepted completion advances its own index by one, and the index wraps from DEPTH-1 to 0.
- R3: A reader completion while the occupancy is 0 is treated as polling. It changes neither the occupancy nor the read index.
- R4: When an accepted reader completion leaves the occupancy at or below the reader-stop level, underrun_fill goes to 1 on that same clock edge and the underrun counter rises by one. While underrun_fill is 1, reader completions are ignored and the read index holds.
- R5: fill_repeat is 1 exactly when underrun_fill is 1 and fill_sel is 1 (repeat the last frame). When underrun_fill is 1 and fill_sel is 0, the fixed template is selected.
- R6: While underrun_fill is 1, writer completions are still accepted and still advance the write index and the occupancy.
- R7: underrun_fill clears only on a clock edge where frame_end is 1 and the resulting occupancy is at or above the reader-start level.
- R8: When an accepted writer completion leaves the occupancy at or above the writer-stop level, hunt goes to 1 and the hunt counter rises by one. While hunt is 1, every writer completion is dropped and counted as a discard, and the occupancy does not rise.
- R9: hunt clears on the edge where the occupancy falls to or below the writer-start level. At that edge the write index moves to one past the first descriptor whose sf_mark bit is 1, searching forward from the current write index with wrap. If no bit is set, the write index is unchanged.
- R10: thr_err is 1 unless reader-stop < reader-start <= writer-start < writer-stop.
- R11: A synchronous active-high reset clears both indices, the occupancy, underrun_fill, hunt and all three counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_done | input | 1 | Writer completed a descriptor |
| rd_done | input | 1 | Reader completed a descriptor |
| frame_end | input | 1 | Reader is at a whole-frame boundary |
| sf_mark | input | DEPTH | Per-descriptor superframe-end flags |
| thr_rd_stop | input | $clog2(DEPTH+1) | Level that freezes the reader |
| thr_rd_start | input | $clog2(DEPTH+1) | Level that releases the reader |
| thr_wr_start | input | $clog2(DEPTH+1) | Level that releases the writer |
| thr_wr_stop | input | $clog2(DEPTH+1) | Level that starts hunt mode |
| fill_sel | input | 1 | 0 selects the fixed template, 1 repeats the last frame |
| wr_idx | output | $clog2(DEPTH) | Write descriptor index |
| rd_idx | output | $clog2(DEPTH) | Read descriptor index |
| occupancy | output | $clog2(DEPTH+1) | Current fill level |
| underrun_fill | output | 1 | Reader frozen, filler being sent |
| fill_repeat | output | 1 | Filler is a repeat of the last frame |
| hunt | output | 1 | Writer in hunt mode, cells dropped |
| thr_err | output | 1 | Thresholds out of order |
| underrun_cnt | output | CNTW | Underrun entries |
| hunt_cnt | output | CNTW | Hunt entries |
| discard_cnt | output | CNTW | Dropped writer completions |

## Verification
The bound checker watches the invariants on every cycle. The occupancy stays within the ring and moves by at most one per edge. The read index holds while the reader is frozen. The write index holds, and the occupancy does not rise, for as long as hunt stays set. Underrun never ends except on a frame boundary. Some behaviour can only be shown by the bench's scenarios. This covers the exact edges at which the thresholds take effect, the superframe realignment target (including the wrap case and the case with no mark), drops and saturation at a full ring, the threshold-order flag, and the reset values.

// File: rtl/jb_slip_pkg.sv
package jb_slip_pkg;
    typedef enum logic {
        FILL_TEMPLATE = 1'b0,
        FILL_REPEAT   = 1'b1
    } fill_mode_e;

    localparam int N_EVENTS = 3;
    localparam int EV_UNDERRUN = 0;
    localparam int EV_HUNT     = 1;
    localparam int EV_DISCARD  = 2;
endpackage

// File: rtl/jb_sf_seek.sv
module jb_sf_seek #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [IW-1:0]    start,
    input  logic [DEPTH-1:0] mark,
    output logic             found,
    output logic [IW-1:0]    target
);
    // Scan from farthest to nearest so the nearest marked slot wins.
    always_comb begin
        int p;
        found  = 1'b0;
        target = start;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            p = int'(start) + k;
            if (p >= DEPTH) p = p - DEPTH;
            if (mark[p]) begin
                found  = 1'b1;
                target = (p == DEPTH - 1) ? '0 : IW'(p + 1);
            end
        end
    end
endmodule

// File: rtl/jb_thr_check.sv
module jb_thr_check #(
    parameter int OW = 5
) (
    input  logic [OW-1:0] rd_stop,
    input  logic [OW-1:0] rd_start,
    input  logic [OW-1:0] wr_start,
    input  logic [OW-1:0] wr_stop,
    output logic          bad
);
    always_comb begin
        bad = !((rd_stop < rd_start) && (rd_start <= wr_start) && (wr_start < wr_stop));
    end
endmodule

// File: rtl/jb_evt_ctr.sv
module jb_evt_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {W{1'b1}})) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/jb_slip_ctrl.sv
module jb_slip_ctrl
    import jb_slip_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNTW  = 16,
    localparam int IW = $clog2(DEPTH),
    localparam int OW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_done,
    input  logic             rd_done,
    input  logic             frame_end,
    input  logic [DEPTH-1:0] sf_mark,
    input  logic [OW-1:0]    thr_rd_stop,
    input  logic [OW-1:0]    thr_rd_start,
    input  logic [OW-1:0]    thr_wr_start,
    input  logic [OW-1:0]    thr_wr_stop,
    input  logic             fill_sel,
    output logic [IW-1:0]    wr_idx,
    output logic [IW-1:0]    rd_idx,
    output logic [OW-1:0]    occupancy,
    output logic             underrun_fill,
    output logic             fill_repeat,
    output logic             hunt,
    output logic             thr_err,
    output logic [CNTW-1:0]  underrun_cnt,
    output logic [CNTW-1:0]  hunt_cnt,
    output logic [CNTW-1:0]  discard_cnt
);
    localparam logic [OW-1:0] FULL    = OW'(DEPTH);
    localparam logic [IW-1:0] LAST_IX = IW'(DEPTH - 1);

    typedef struct packed {
        logic [IW-1:0] wr;
        logic [IW-1:0] rd;
        logic [OW-1:0] occ;
        logic          und;
        logic          hunt;
    } core_t;

    core_t st_d, st_q;
    logic  wr_ok, rd_ok;
    logic  seek_found;
    logic  [IW-1:0] seek_target;
    logic  [N_EVENTS-1:0] evt_inc;
    logic  [CNTW-1:0] evt_cnt [N_EVENTS];

    jb_sf_seek #(.DEPTH(DEPTH)) u_seek (
        .start  (st_q.wr),
        .mark   (sf_mark),
        .found  (seek_found),
        .target (seek_target)
    );

    jb_thr_check #(.OW(OW)) u_thr (
        .rd_stop  (thr_rd_stop),
        .rd_start (thr_rd_start),
        .wr_start (thr_wr_start),
        .wr_stop  (thr_wr_stop),
        .bad      (thr_err)
    );

    function automatic logic [IW-1:0] ring_next(input logic [IW-1:0] i);
        return (i == LAST_IX) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        wr_ok   = wr_done && !st_q.hunt && (st_q.occ != FULL);
        rd_ok   = rd_done && !st_q.und  && (st_q.occ != '0);
        evt_inc = '0;

        if (wr_ok) st_d.wr = ring_next(st_q.wr);
        if (rd_ok) st_d.rd = ring_next(st_q.rd);

        unique case ({wr_ok, rd_ok})
            2'b10:   st_d.occ = st_q.occ + 1'b1;
            2'b01:   st_d.occ = st_q.occ - 1'b1;
            default: st_d.occ = st_q.occ;
        endcase

        // Reader side: freeze near empty, release on a frame boundary.
        if (st_q.und) begin
            if (frame_end && (st_d.occ >= thr_rd_start)) st_d.und = 1'b0;
        end else if (rd_ok && (st_d.occ <= thr_rd_stop)) begin
            st_d.und = 1'b1;
            evt_inc[EV_UNDERRUN] = 1'b1;
        end

        // Writer side: hunt near full, realign after release.
        if (st_q.hunt) begin
            if (st_d.occ <= thr_wr_start) begin
                st_d.hunt = 1'b0;
                if (seek_found) st_d.wr = seek_target;
            end
        end else if (wr_ok && (st_d.occ >= thr_wr_stop)) begin
            st_d.hunt = 1'b1;
            evt_inc[EV_HUNT] = 1'b1;
        end

        evt_inc[EV_DISCARD] = wr_done && !wr_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < N_EVENTS; g++) begin : g_evt
        jb_evt_ctr #(.W(CNTW)) u_ctr (
            .clk (clk),
            .rst (rst),
            .inc (evt_inc[g]),
            .cnt (evt_cnt[g])
        );
    end

    assign wr_idx        = st_q.wr;
    assign rd_idx        = st_q.rd;
    assign occupancy     = st_q.occ;
    assign underrun_fill = st_q.und;
    assign fill_repeat   = st_q.und && (fill_mode_e'(fill_sel) == FILL_REPEAT);
    assign hunt          = st_q.hunt;
    assign underrun_cnt  = evt_cnt[EV_UNDERRUN];
    assign hunt_cnt      = evt_cnt[EV_HUNT];
    assign discard_cnt   = evt_cnt[EV_DISCARD];
endmodule

// File: rtl/jb_slip_ctrl_chk.sv
module jb_slip_ctrl_chk #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH),
    localparam int OW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          frame_end,
    input logic [IW-1:0] wr_idx,
    input logic [IW-1:0] rd_idx,
    input logic [OW-1:0] occupancy,
    input logic          underrun_fill,
    input logic          hunt
);
    AST_OCC_IN_RING: assert property (@(posedge clk) disable iff (rst)
        occupancy <= OW'(DEPTH)); // R1
    AST_OCC_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        ((occupancy == $past(occupancy)) || (occupancy == $past(occupancy) + 1'b1)
         || (occupancy + 1'b1 == $past(occupancy)))); // R1
    AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_idx) < DEPTH) && (int'(rd_idx) < DEPTH)); // R2
    AST_RD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        underrun_fill |=> $stable(rd_idx)); // R4
    AST_EXIT_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(underrun_fill) |-> $past(frame_end)); // R7
    AST_HUNT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        hunt |=> (occupancy <= $past(occupancy))); // R8
    AST_HUNT_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        hunt |=> (!hunt || $stable(wr_idx))); // R9
endmodule

bind jb_slip_ctrl jb_slip_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_end     (frame_end),
    .wr_idx        (wr_idx),
    .rd_idx        (rd_idx),
    .occupancy     (occupancy),
    .underrun_fill (underrun_fill),
    .hunt          (hunt)
);

// File: tb/sim_jb_slip_ctrl.sv
module sim_jb_slip_ctrl;
    localparam int DEPTH = 16;
    localparam int CNTW  = 16;
    localparam int IW = $clog2(DEPTH);
    localparam int OW = $clog2(DEPTH + 1);
    localparam int NV = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_done = 1'b0, rd_done = 1'b0, frame_end = 1'b0;
    logic [DEPTH-1:0] sf_mark = '0;
    logic [OW-1:0] thr_rd_stop = 5'd2, thr_rd_start = 5'd4, thr_wr_start = 5'd10, thr_wr_stop = 5'd13;
    logic fill_sel = 1'b0;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [OW-1:0] occupancy;
    logic underrun_fill, fill_repeat, hunt, thr_err;
    logic [CNTW-1:0] underrun_cnt, hunt_cnt, discard_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    jb_slip_ctrl #(.DEPTH(DEPTH), .CNTW(CNTW)) u0 (
        .clk(clk), .rst(rst), .wr_done(wr_done), .rd_done(rd_done),
        .frame_end(frame_end), .sf_mark(sf_mark),
        .thr_rd_stop(thr_rd_stop), .thr_rd_start(thr_rd_start),
        .thr_wr_start(thr_wr_start), .thr_wr_stop(thr_wr_stop),
        .fill_sel(fill_sel), .wr_idx(wr_idx), .rd_idx(rd_idx),
        .occupancy(occupancy), .underrun_fill(underrun_fill),
        .fill_repeat(fill_repeat), .hunt(hunt), .thr_err(thr_err),
        .underrun_cnt(underrun_cnt), .hunt_cnt(hunt_cnt), .discard_cnt(discard_cnt)
    );

    // Row: {req[3:0], wr,rd,fe, occ[4:0], wr_idx[3:0], rd_idx[3:0], und, hunt}
    localparam logic [21:0] VEC [NV] = '{
        {4'd3,  3'b010, 5'd0,  4'd0,  4'd0, 2'b00}, // R3 poll while empty
        {4'd1,  3'b100, 5'd1,  4'd1,  4'd0, 2'b00}, // R1
        {4'd2,  3'b100, 5'd2,  4'd2,  4'd0, 2'b00}, // R2
        {4'd1,  3'b100, 5'd3,  4'd3,  4'd0, 2'b00}, // R1
        {4'd1,  3'b110, 5'd3,  4'd4,  4'd1, 2'b00}, // R1 simultaneous
        {4'd4,  3'b010, 5'd2,  4'd4,  4'd2, 2'b10}, // R4 enter underrun
        {4'd4,  3'b010, 5'd2,  4'd4,  4'd2, 2'b10}, // R4 reader frozen
        {4'd7,  3'b001, 5'd2,  4'd4,  4'd2, 2'b10}, // R7 frame but level low
        {4'd6,  3'b100, 5'd3,  4'd5,  4'd2, 2'b10}, // R6 writer continues
        {4'd7,  3'b100, 5'd4,  4'd6,  4'd2, 2'b10}, // R7 level ok, no frame
        {4'd7,  3'b101, 5'd5,  4'd7,  4'd2, 2'b00}, // R7 exit on frame
        {4'd2,  3'b010, 5'd4,  4'd7,  4'd3, 2'b00}, // R2
        {4'd1,  3'b100, 5'd5,  4'd8,  4'd3, 2'b00},
        {4'd1,  3'b100, 5'd6,  4'd9,  4'd3, 2'b00},
        {4'd1,  3'b100, 5'd7,  4'd10, 4'd3, 2'b00},
        {4'd1,  3'b100, 5'd8,  4'd11, 4'd3, 2'b00},
        {4'd1,  3'b100, 5'd9,  4'd12, 4'd3, 2'b00},
        {4'd1,  3'b100, 5'd10, 4'd13, 4'd3, 2'b00},
        {4'd1,  3'b100, 5'd11, 4'd14, 4'd3, 2'b00},
        {4'd1,  3'b100, 5'd12, 4'd15, 4'd3, 2'b00},
        {4'd8,  3'b100, 5'd13, 4'd0,  4'd3, 2'b01}, // R8 enter hunt, R2 wrap
        {4'd8,  3'b100, 5'd13, 4'd0,  4'd3, 2'b01}, // R8 cell dropped
        {4'd8,  3'b010, 5'd12, 4'd0,  4'd4, 2'b01}, // R8
        {4'd9,  3'b010, 5'd11, 4'd0,  4'd5, 2'b01}, // R9
        {4'd9,  3'b010, 5'd10, 4'd6,  4'd6, 2'b00}  // R9 realign past mark 5
    };

    task automatic check(input int req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic cyc(input logic w, input logic r, input logic f);
        @(negedge clk);
        wr_done = w; rd_done = r; frame_end = f;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_done = 1'b0; rd_done = 1'b0; frame_end = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        sf_mark = 16'h0020;
        do_reset();
        // R11 reset state
        check(11, "occupancy", occupancy, 0);
        check(11, "wr_idx", wr_idx, 0);
        check(11, "rd_idx", rd_idx, 0);
        check(11, "flags", {underrun_fill, hunt}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            v = VEC[i];
            cyc(v[17], v[16], v[15]);
            check(int'(v[21:18]), "occupancy", occupancy, int'(v[14:10]));
            check(int'(v[21:18]), "wr_idx", wr_idx, int'(v[9:6]));
            check(int'(v[21:18]), "rd_idx", rd_idx, int'(v[5:2]));
            check(int'(v[21:18]), "underrun_fill", underrun_fill, int'(v[1]));
            check(int'(v[21:18]), "hunt", hunt, int'(v[0]));
        end
        check(4, "underrun_cnt", underrun_cnt, 1);   // R4
        check(8, "hunt_cnt", hunt_cnt, 1);           // R8
        check(8, "discard_cnt", discard_cnt, 1);     // R8

        // R11 mid-run reset clears everything
        do_reset();
        check(11, "occupancy", occupancy, 0);
        check(11, "wr_idx", wr_idx, 0);
        check(11, "rd_idx", rd_idx, 0);
        check(11, "counters", int'(underrun_cnt) + int'(hunt_cnt) + int'(discard_cnt), 0);

        // R5 filler selection
        fill_sel = 1'b1;
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 1, 0);
        check(5, "underrun_fill", underrun_fill, 1);
        check(5, "fill_repeat sel=1", fill_repeat, 1);
        @(negedge clk); fill_sel = 1'b0; #1;
        check(5, "fill_repeat sel=0", fill_repeat, 0);
        check(5, "underrun_fill sel=0", underrun_fill, 1);

        // R10 threshold order flag
        @(negedge clk); thr_rd_start = 5'd2; #1;
        check(10, "thr_err rd_start=rd_stop", thr_err, 1);
        @(negedge clk); thr_rd_start = 5'd4; #1;
        check(10, "thr_err valid", thr_err, 0);
        @(negedge clk); thr_wr_start = 5'd13; #1;
        check(10, "thr_err wr_start=wr_stop", thr_err, 1);
        @(negedge clk); thr_wr_start = 5'd3; #1;
        check(10, "thr_err rd_start>wr_start", thr_err, 1);
        @(negedge clk); thr_wr_start = 5'd10; #1;

        // R1 saturation at a full ring
        thr_rd_stop = 5'd0; thr_rd_start = 5'd1; thr_wr_start = 5'd15; thr_wr_stop = 5'd31;
        do_reset();
        for (int k = 0; k < DEPTH + 1; k++) cyc(1, 0, 0);
        check(1, "occupancy full", occupancy, DEPTH);
        check(1, "wr_idx full", wr_idx, 0);
        check(1, "discard when full", discard_cnt, 1);
        check(1, "hunt when full", hunt, 0);

        // R9 no mark: write index unchanged at hunt exit
        thr_rd_stop = 5'd2; thr_rd_start = 5'd4; thr_wr_start = 5'd10; thr_wr_stop = 5'd13;
        sf_mark = '0;
        do_reset();
        for (int k = 0; k < 13; k++) cyc(1, 0, 0);
        check(8, "hunt entered", hunt, 1);
        for (int k = 0; k < 3; k++) cyc(0, 1, 0);
        check(9, "hunt cleared", hunt, 0);
        check(9, "wr_idx no mark", wr_idx, 13);

        // R9 search wraps: mark at 2 from write index 13 gives 3
        sf_mark = 16'h0004;
        do_reset();
        for (int k = 0; k < 13; k++) cyc(1, 0, 0);
        for (int k = 0; k < 3; k++) cyc(0, 1, 0);
        check(9, "wr_idx wrapped seek", wr_idx, 3);
        check(9, "occupancy after exit", occupancy, 10);

        summary();
    end
endmodule